// File: doc/BRIEF.md
# Ready/Valid Synchronous Queue with Optional Pipe and Flow Bypass

This block is a first-in first-out buffer between a producer and a consumer that both use a ready/valid handshake. A word moves on a port only at a rising clock edge where that port's valid and ready are both high. An occupancy output reports how many words the queue holds. Data width and depth are parameters, and the depth does not have to be a power of two.

Two elaboration-time switches change behaviour at the boundaries. With the pipe option, a full queue still takes a new word in any cycle where the consumer is taking one, so even a single-entry queue can move one word per cycle. With the flow option, an empty queue passes an arriving word straight to its output in the same cycle. If the consumer takes that word at once, it never enters storage.

Reset is synchronous and active high. The whole block runs on one clock.

Top module: `hs_queue`

## Requirements
- R1: `enqReady` is high whenever `count` is below DEPTH. Without the pipe option it is low whenever `count` equals DEPTH.
- R2: `deqValid` is high whenever `count` is non-zero. Without the flow option it is low whenever `count` is zero.
- R3: `count` stays within 0..DEPTH. It rises by one after an edge with only an enqueue transfer, falls by one after an edge with only a dequeue transfer, and stays the same after an edge with both.
- R4: An offer that is not accepted (`enqValid` high while `enqReady` is low) has no effect. `count` and the word order do not change.
- R5: With the pipe option, `enqReady` is high while the queue is full if `deqReady` is high. It is low only when `count` equals DEPTH and `deqReady` is low.
- R6: With the pipe option and DEPTH of 1, holding `enqValid` and `deqReady` high gives one dequeue per cycle from the second cycle onward.
- R7: With the flow option, an empty queue raises `deqValid` in the same cycle as `enqValid` and shows `enqData` on `deqData`. `deqValid` is low only when `count` is zero and `enqValid` is low.
- R8: With the flow option, a word that is enqueued and dequeued in the same cycle while the queue is empty is not stored, and `count` stays at zero.
- R9: Words leave in the order they entered, with no loss and no duplication, under random `enqValid` and `deqReady` patterns.
- R10: While `rst` is high at a clock edge, the queue is emptied: after that edge `count` is zero and, with `enqValid` low, `deqValid` is low.
- R11: A DEPTH that is not a power of two wraps both pointers at DEPTH-1 and keeps the word order across many wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enqValid | input | 1 | Producer offers `enqData` |
| enqReady | output | 1 | Queue accepts an offered word this cycle |
| enqData | input | DATA_W | Word offered by the producer |
| deqValid | output | 1 | `deqData` holds a word for the consumer |
| deqReady | input | 1 | Consumer takes the word this cycle |
| deqData | output | DATA_W | Oldest word, or the arriving word when flow bypass is active |
| count | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
The bench drives three instances at once. The first is a plain queue with a power-of-two depth, the second a single-entry pipe queue, and the third a depth-3 flow queue. The corner cases are a full queue that is offered more words, a full pipe queue that is drained and refilled in one edge, and an empty flow queue whose word passes straight through. A design that ignored the full condition would overwrite the oldest word. A pipe queue that waited for space would halve throughput at depth 1. A flow queue that stored bypassed words would duplicate them or leave `count` non-zero. Long random runs with a mid-run reset expose pointer wrap errors at the non-power-of-two depth as out-of-order data.

// File: rtl/hs_queue_pkg.sv
package hs_queue_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // write enqData into the slot at wrPtr
    logic passThru;  // steer enqData to deqData (flow with empty queue)
  } qStrobe_t;
endpackage

// File: rtl/hs_queue_ctrl.sv
module hs_queue_ctrl
  import hs_queue_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter bit PIPE  = 1'b0,
  parameter bit FLOW  = 1'b0,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enqValid,
  input  logic             deqReady,
  output logic             enqReady,
  output logic             deqValid,
  output logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output qStrobe_t         strobe
);
  localparam bit IS_POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt;
  logic isFull, isEmpty, enqFire, deqFire, doWrite, doRead;
  logic [PTR_W-1:0] wrNext, rdNext;

  assign isFull  = (cnt == CNT_W'(DEPTH));
  assign isEmpty = (cnt == '0);

  assign enqReady = !isFull || (PIPE && deqReady);
  assign deqValid = !isEmpty || (FLOW && enqValid);

  assign enqFire = enqValid && enqReady;
  assign deqFire = deqValid && deqReady;

  // bypassed words are neither stored nor read from storage
  assign doWrite = enqFire && !(FLOW && isEmpty && deqReady);
  assign doRead  = deqFire && !isEmpty;

  assign strobe.wrEn     = doWrite;
  assign strobe.passThru = FLOW && isEmpty;

  generate
    if (IS_POW2) begin : g_natWrap
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_cmpWrap
      assign wrNext = (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doWrite) wrPtr <= wrNext;
      if (doRead)  rdPtr <= rdNext;
      case ({doWrite, doRead})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign count = cnt;
endmodule

// File: rtl/hs_queue_data.sv
module hs_queue_data
  import hs_queue_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  qStrobe_t          strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0] enqData,
  output logic [DATA_W-1:0] deqData
);
  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) slots[wrPtr] <= enqData;
  end

  assign deqData = strobe.passThru ? enqData : slots[rdPtr];
endmodule

// File: rtl/hs_queue.sv
module hs_queue
  import hs_queue_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter bit PIPE   = 1'b0,
  parameter bit FLOW   = 1'b0,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enqValid,
  output logic              enqReady,
  input  logic [DATA_W-1:0] enqData,
  output logic              deqValid,
  input  logic              deqReady,
  output logic [DATA_W-1:0] deqData,
  output logic [CNT_W-1:0]  count
);
  qStrobe_t         strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  hs_queue_ctrl #(
    .DEPTH(DEPTH), .PIPE(PIPE), .FLOW(FLOW), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enqValid(enqValid), .deqReady(deqReady),
    .enqReady(enqReady), .deqValid(deqValid), .count(count),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .strobe(strobe)
  );

  hs_queue_data #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
  ) u_data (
    .clk(clk), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .enqData(enqData), .deqData(deqData)
  );
endmodule

// File: rtl/hs_queue_chk.sv
module hs_queue_chk #(
  parameter int DEPTH = 4,
  parameter bit PIPE  = 1'b0,
  parameter bit FLOW  = 1'b0,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             enqValid,
  input logic             enqReady,
  input logic             deqValid,
  input logic             deqReady,
  input logic [CNT_W-1:0] count
);
  logic enqFire, deqFire;
  assign enqFire = enqValid && enqReady;
  assign deqFire = deqValid && deqReady;

  assert_enq_ready_R1: assert property (@(posedge clk) disable iff (rst)
    (count != CNT_W'(DEPTH)) |-> enqReady);
  assert_deq_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |-> deqValid);
  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (enqFire && deqFire) |=> (count == $past(count)));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (!enqFire && !deqFire) |=> $stable(count));
  assert_reset_empty_R10: assert property (@(posedge clk)
    rst |=> (count == '0));

  generate
    if (PIPE) begin : g_pipe
      assert_pipe_ready_R5: assert property (@(posedge clk) disable iff (rst)
        !enqReady |-> (count == CNT_W'(DEPTH) && !deqReady));
    end else begin : g_noPipe
      assert_full_block_R1: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) |-> !enqReady);
    end
    if (FLOW) begin : g_flow
      assert_flow_valid_R7: assert property (@(posedge clk) disable iff (rst)
        !deqValid |-> (count == '0 && !enqValid));
      assert_flow_nostore_R8: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && enqValid && deqReady) |=> (count == '0));
    end else begin : g_noFlow
      assert_empty_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !deqValid);
    end
  endgenerate
endmodule

bind hs_queue hs_queue_chk #(
  .DEPTH(DEPTH), .PIPE(PIPE), .FLOW(FLOW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .enqValid(enqValid), .enqReady(enqReady),
  .deqValid(deqValid), .deqReady(deqReady), .count(count)
);

// File: tb/hs_queue_tb.sv
`timescale 1ns/1ps
module hs_queue_tb;
  localparam int N = 3;

  function automatic int depOf(int i);
    return (i == 0) ? 4 : ((i == 1) ? 1 : 3);
  endfunction
  function automatic bit pipeOf(int i);
    return i == 1;
  endfunction
  function automatic bit flowOf(int i);
    return i == 2;
  endfunction

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst;

  logic       ev [N];
  logic       dr [N];
  logic [7:0] ed [N];
  logic       er [N];
  logic       dv [N];
  logic [7:0] dd [N];
  logic [3:0] cnt [N];
  logic [2:0] c0;
  logic [0:0] c1;
  logic [1:0] c2;

  always_comb begin
    cnt[0] = 4'(c0);
    cnt[1] = 4'(c1);
    cnt[2] = 4'(c2);
  end

  hs_queue #(.DATA_W(8), .DEPTH(4), .PIPE(1'b0), .FLOW(1'b0)) u_dut (
    .clk(clk), .rst(rst), .enqValid(ev[0]), .enqReady(er[0]), .enqData(ed[0]),
    .deqValid(dv[0]), .deqReady(dr[0]), .deqData(dd[0]), .count(c0));
  hs_queue #(.DATA_W(8), .DEPTH(1), .PIPE(1'b1), .FLOW(1'b0)) u_pipe (
    .clk(clk), .rst(rst), .enqValid(ev[1]), .enqReady(er[1]), .enqData(ed[1]),
    .deqValid(dv[1]), .deqReady(dr[1]), .deqData(dd[1]), .count(c1));
  hs_queue #(.DATA_W(8), .DEPTH(3), .PIPE(1'b0), .FLOW(1'b1)) u_flow (
    .clk(clk), .rst(rst), .enqValid(ev[2]), .enqReady(er[2]), .enqData(ed[2]),
    .deqValid(dv[2]), .deqReady(dr[2]), .deqData(dd[2]), .count(c2));

  // reference model
  logic [7:0] mbuf [N][8];
  int head [N];
  int n [N];
  logic [7:0] nextD [N];
  int deqCount [N];
  int checks = 0;
  int fails = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < N; i++) begin
      head[i] = 0;
      n[i] = 0;
    end
  endtask

  // called just after a falling edge with ev/dr already set
  task automatic step();
    bit enF [N];
    bit deF [N];
    for (int i = 0; i < N; i++) ed[i] = nextD[i];
    #1;
    for (int i = 0; i < N; i++) begin
      bit expRdy, expVal;
      int expData;
      expRdy = (n[i] < depOf(i)) || (pipeOf(i) && dr[i]);
      expVal = (n[i] > 0) || (flowOf(i) && ev[i]);
      chk(pipeOf(i) ? "R5 enqReady" : "R1 enqReady", int'(er[i]), int'(expRdy));
      chk(flowOf(i) ? "R7 deqValid" : "R2 deqValid", int'(dv[i]), int'(expVal));
      chk(flowOf(i) ? "R3/R8 count" : "R3 count", int'(cnt[i]), n[i]);
      enF[i] = ev[i] && expRdy;
      deF[i] = expVal && dr[i];
      if (deF[i]) begin
        expData = (n[i] > 0) ? int'(mbuf[i][head[i]]) : int'(ed[i]);
        chk((n[i] == 0) ? "R7 passthru data" : ((i == 2) ? "R9/R11 data" : "R9 data"),
            int'(dd[i]), expData);
      end
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (deF[i]) deqCount[i]++;
      if (!(n[i] == 0 && flowOf(i) && enF[i] && deF[i])) begin
        if (deF[i]) begin
          head[i] = (head[i] + 1) % 8;
          n[i]--;
        end
        if (enF[i]) begin
          mbuf[i][(head[i] + n[i]) % 8] = ed[i];
          n[i]++;
        end
      end
      if (enF[i]) nextD[i] = nextD[i] + 8'd1;
    end
    @(negedge clk);
  endtask

  task automatic idleAll();
    for (int i = 0; i < N; i++) begin
      ev[i] = 1'b0;
      dr[i] = 1'b0;
    end
  endtask

  task automatic checkReset();
    #1;
    for (int i = 0; i < N; i++) begin
      chk("R10 count after reset", int'(cnt[i]), 0);
      chk("R10 deqValid after reset", int'(dv[i]), 0);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int seedSink;
    seedSink = $urandom(32'd2024);
    rst = 1'b1;
    idleAll();
    for (int i = 0; i < N; i++) begin
      nextD[i] = 8'(i * 80);
      ed[i] = nextD[i];
      deqCount[i] = 0;
    end
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkReset();
    @(negedge clk);

    // R1/R4: fill the plain queue and keep offering while full
    idleAll();
    ev[0] = 1'b1;
    repeat (7) step();
    #1;
    chk("R4 count held at full", int'(cnt[0]), 4);
    chk("R1 enqReady low when full", int'(er[0]), 0);
    @(negedge clk);
    ev[0] = 1'b0;
    dr[0] = 1'b1;
    repeat (5) step();

    // R6: single-entry pipe queue streams one word per cycle
    idleAll();
    deqCount[1] = 0;
    ev[1] = 1'b1;
    dr[1] = 1'b1;
    repeat (50) step();
    chk("R6 pipe depth1 dequeues in 50 cycles", deqCount[1], 49);

    // R5: full pipe queue refilled on a draining edge
    idleAll();
    ev[1] = 1'b1;
    step();
    step();
    dr[1] = 1'b1;
    repeat (4) step();

    // R7/R8: flow queue passes words straight through while empty
    idleAll();
    ev[2] = 1'b1;
    dr[2] = 1'b1;
    repeat (10) step();
    #1;
    chk("R8 flow count stays zero", int'(cnt[2]), 0);
    @(negedge clk);

    // R9/R11: random traffic, two bias settings
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < N; i++) begin
        ev[i] = ($urandom % 4) != 0;
        dr[i] = (k < 2000) ? ($urandom % 2 == 0) : ($urandom % 4 != 0);
      end
      step();
    end

    // R10: reset in the middle of traffic
    for (int i = 0; i < N; i++) begin
      ev[i] = 1'b1;
      dr[i] = 1'b0;
    end
    repeat (2) step();
    idleAll();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelClear();
    checkReset();
    @(negedge clk);
    for (int k = 0; k < 200; k++) begin
      for (int i = 0; i < N; i++) begin
        ev[i] = $urandom % 2 == 0;
        dr[i] = $urandom % 2 == 0;
      end
      step();
    end

    summary();
    $finish;
  end
endmodule